// File: doc/BRIEF.md
# Fractional-Prescaler Baud Generator

This block derives the two timing strobes that a 16550-style UART core needs from a fixed 62.5 MHz reference clock. The reference passes through three stages in series. The first is a prescaler with 1/8 resolution, from 1 to 63.875. The second is a 16-bit integer divisor. The third is an oversampling counter with a modulus from 4 to 16. The outputs are `sample_tick`, one clock wide at the oversampled rate, and `bit_tick`, one clock wide at the final baud rate.

Software programs the block through a byte-wide register write port and can read every register back. The prescaler only leaves its power-on value of 33.875 once an extended-mode bit is set. With that power-on value and an oversampling modulus of 16, the divisor sees a reference near 115.3 kHz, so legacy divisor values still give the usual rates. Writing the low prescaler byte clears its ninth bit, so software writes the low byte first and the high bit second.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the readback is: address 0 = 0x01, 1 = 0x00, 2 = 0x0F, 3 = 0x01, 4 = 0x00, 5 = 0x00. Unmapped addresses read 0x00. Both ticks are low while reset is held.
- R2: Register map: address 0 holds the divisor bits 7:0 and address 1 holds bits 15:8. Address 2 holds the prescaler bits 7:0 in eighths, and address 3 bit 0 holds prescaler bit 8. Address 4 bits 3:0 hold the oversampling code. Address 5 bit 0 is the extended-mode enable and bit 1 is the prescaler enable. Every stored field reads back at its address, and all other bits read 0.
- R3: While extended mode is off, writes to addresses 2 and 3 are ignored and the prescaler acts as 271/8, whatever the prescaler enable holds.
- R4: With extended mode on and the prescaler enable clear, the prescaler acts as 1: one prescaler output for every reference clock.
- R5: With both enables set, eight consecutive `sample_tick` pulses span exactly raw×D clocks, where raw is the 9-bit prescaler value and D is the effective divisor. Eight consecutive `bit_tick` pulses span raw×D×S clocks, where S is the oversampling modulus.
- R6: In extended mode, any write to address 2 clears prescaler bit 8. A write to address 3 sets bit 8 from data bit 0.
- R7: Raw prescaler values below 8 act as 8, a factor of 1.
- R8: Oversampling codes 4 to 15 select that modulus, and codes 0 to 3 select 16. Code 4 together with factor 1 and divisor 1 gives a `bit_tick` every 4 clocks (15.625 Mbaud).
- R9: A divisor of 0 acts as 1.
- R10: A divisor write restarts the divisor and oversampling counters on the next prescaler output. With the prescaler bypassed, the first `bit_tick` comes D×S+2 clocks after the write edge.
- R11: Each `bit_tick` lasts one clock and follows a `sample_tick` in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 62.5 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register readback (combinational) |
| sample_tick | output | 1 | Oversampling-rate strobe |
| bit_tick | output | 1 | Baud-rate strobe |

## Verification
The tick spacing is measured over eight intervals, so the fractional prescaler is checked for exactness and not just for its average rate. Several settings are tried. The power-on value 271 checks the legacy path. An integer raw value of 12 and an odd raw value of 13 with divisor 2 check the fraction handling. A bypassed prescaler with divisor 3 and modulus 5 separates the bypass from the fraction path. Clamp cases use raw values 3 and 0, divisor 0, and oversampling codes 0, 1, 3, 15 and 4; each case tells its clamp apart from passing the value through. Separate cases cover prescaler writes with extended mode off, the write order of the two prescaler registers, and the exact cycle of the first `bit_tick` after a divisor write.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
    localparam int FRAC_BITS = 3;
    localparam int PRE_W     = 9;
    localparam int DIV_W     = 16;
    localparam int OVS_W     = 4;
    localparam int OVS_CW    = OVS_W + 1;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int ACC_W     = PRE_W + 1;
    localparam int OVS_MIN   = 4;
    localparam int OVS_MAX   = 16;

    localparam logic [PRE_W-1:0] PRE_UNITY = PRE_W'(1 << FRAC_BITS);
    localparam logic [PRE_W-1:0] PRE_RESET = PRE_W'(271);

    typedef enum logic [ADDR_W-1:0] {
        A_DIV_LO = 3'd0,
        A_DIV_HI = 3'd1,
        A_PRE_LO = 3'd2,
        A_PRE_HI = 3'd3,
        A_OVS    = 3'd4,
        A_CTRL   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PRE_W-1:0] pre;
        logic [OVS_W-1:0] ovs;
        logic             ext_en;
        logic             pre_en;
    } cfg_t;
endpackage

// File: rtl/ubg_regs.sv
module ubg_regs
    import ubg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg,
    output logic              div_wr,
    output logic              pre_wr
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d  = cfg_q;
        div_wr = 1'b0;
        pre_wr = 1'b0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_DIV_LO: begin
                    cfg_d.div[7:0] = wr_data;
                    div_wr         = 1'b1;
                end
                A_DIV_HI: begin
                    cfg_d.div[15:8] = wr_data;
                    div_wr          = 1'b1;
                end
                A_PRE_LO: if (cfg_q.ext_en) begin
                    cfg_d.pre = {1'b0, wr_data};
                    pre_wr    = 1'b1;
                end
                A_PRE_HI: if (cfg_q.ext_en) begin
                    cfg_d.pre[PRE_W-1] = wr_data[0];
                    pre_wr             = 1'b1;
                end
                A_OVS: cfg_d.ovs = wr_data[OVS_W-1:0];
                A_CTRL: begin
                    cfg_d.ext_en = wr_data[0];
                    cfg_d.pre_en = wr_data[1];
                    pre_wr       = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_DIV_LO: rd_data = cfg_q.div[7:0];
            A_DIV_HI: rd_data = cfg_q.div[15:8];
            A_PRE_LO: rd_data = cfg_q.pre[7:0];
            A_PRE_HI: rd_data = {7'd0, cfg_q.pre[PRE_W-1]};
            A_OVS:    rd_data = {{(DATA_W-OVS_W){1'b0}}, cfg_q.ovs};
            A_CTRL:   rd_data = {6'd0, cfg_q.pre_en, cfg_q.ext_en};
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.div    <= DIV_W'(1);
            cfg_q.pre    <= PRE_RESET;
            cfg_q.ovs    <= '0;
            cfg_q.ext_en <= 1'b0;
            cfg_q.pre_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/ubg_prescaler.sv
module ubg_prescaler
    import ubg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] step,
    output logic             tick
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } st_t;

    st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        sum       = st_q.acc + ACC_W'(PRE_UNITY);
        if (clr) begin
            st_d.acc = '0;
        end else if (sum >= ACC_W'(step)) begin
            st_d.acc  = sum - ACC_W'(step);
            st_d.tick = 1'b1;
        end else begin
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/ubg_count_stage.sv
module ubg_count_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick_in,
    input  logic [W-1:0] limit,
    output logic         tick_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            if (st_q.cnt >= limit - W'(1)) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_out = st_q.tick;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import ubg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    cfg_t              cfg_s;
    logic              div_wr, pre_wr, pre_tick, restart;
    logic              pend_d, pend_q;
    logic [PRE_W-1:0]  pre_eff;
    logic [DIV_W-1:0]  div_eff;
    logic [OVS_CW-1:0] ovs_eff;

    ubg_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg(cfg_s), .div_wr(div_wr), .pre_wr(pre_wr)
    );

    always_comb begin
        if (!cfg_s.ext_en)                 pre_eff = PRE_RESET;
        else if (!cfg_s.pre_en)            pre_eff = PRE_UNITY;
        else if (cfg_s.pre < PRE_UNITY)    pre_eff = PRE_UNITY;
        else                               pre_eff = cfg_s.pre;

        div_eff = (cfg_s.div == '0) ? DIV_W'(1) : cfg_s.div;

        if (cfg_s.ovs < OVS_W'(OVS_MIN))   ovs_eff = OVS_CW'(OVS_MAX);
        else                               ovs_eff = OVS_CW'(cfg_s.ovs);

        restart = pend_q && pre_tick;
        if (div_wr)       pend_d = 1'b1;
        else if (restart) pend_d = 1'b0;
        else              pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    ubg_prescaler i_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_wr), .step(pre_eff), .tick(pre_tick)
    );

    ubg_count_stage #(.W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .clr(restart), .tick_in(pre_tick),
        .limit(div_eff), .tick_out(sample_tick)
    );

    ubg_count_stage #(.W(OVS_CW)) i_ovs (
        .clk(clk), .rst_n(rst_n), .clr(restart), .tick_in(sample_tick),
        .limit(ovs_eff), .tick_out(bit_tick)
    );
endmodule

// File: rtl/ubg_checker.sv
module ubg_checker
    import ubg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sample_tick,
    input logic              bit_tick,
    input logic              ext_en,
    input logic [PRE_W-1:0]  pre_raw,
    input logic [OVS_W-1:0]  ovs_raw
);
    // R11
    bit_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(sample_tick));

    // R11
    bit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R6
    pre_lo_clears_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PRE_LO && ext_en) |=> !pre_raw[PRE_W-1]);

    // R3
    pre_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_PRE_LO || wr_addr == A_PRE_HI) && !ext_en)
            |=> $stable(pre_raw));

    // R2
    ovs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OVS) |=> ovs_raw == $past(wr_data[OVS_W-1:0]));
endmodule

bind uart_baud_gen ubg_checker i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .ext_en(cfg_s.ext_en), .pre_raw(cfg_s.pre), .ovs_raw(cfg_s.ovs)
);

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sample_tick, bit_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    uart_baud_gen i_uart_baud_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 195000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_addr = 3'(a); #1;
        d = int'(rd_data);
    endtask

    // cycles spanned by eight intervals of the chosen tick
    task automatic span(input bit use_bit, output int s);
        int idx = 0;
        int first = 0;
        int seen = 0;
        while (seen < 9 && idx < 70000) begin
            @(posedge clk); #1;
            idx++;
            if (use_bit ? bit_tick : sample_tick) begin
                if (seen == 0) first = idx;
                seen++;
            end
        end
        s = idx - first;
    endtask

    task automatic t_reset();
        int v;
        int bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (sample_tick || bit_tick) bad++;
        end
        check("R1 ticks in reset", bad, 0);
        rst_n = 1'b1;
        rd(0, v); check("R1 div lo", v, 8'h01);
        rd(1, v); check("R1 div hi", v, 8'h00);
        rd(2, v); check("R1 pre lo", v, 8'h0F);
        rd(3, v); check("R1 pre hi", v, 8'h01);
        rd(4, v); check("R1 ovs", v, 8'h00);
        rd(5, v); check("R1 ctrl", v, 8'h00);
        rd(6, v); check("R1 unmapped", v, 8'h00);
    endtask

    task automatic t_default();
        int s;
        span(1'b0, s); check("R3 default sample span", s, 271);
        span(1'b1, s); check("R3 default bit span", s, 271 * 16);
    endtask

    task automatic t_locked();
        int v, s;
        wr(2, 8'h40); wr(3, 8'h00); wr(5, 8'h02);
        rd(2, v); check("R3 pre lo locked", v, 8'h0F);
        rd(3, v); check("R3 pre hi locked", v, 8'h01);
        span(1'b0, s); check("R3 pre_en ignored w/o ext", s, 271);
    endtask

    task automatic t_bypass();
        int v, s;
        wr(5, 8'h01); wr(0, 3); wr(4, 5);
        rd(5, v); check("R2 ctrl readback", v, 8'h01);
        span(1'b0, s); check("R4 bypass sample span", s, 8 * 3);
        span(1'b1, s); check("R4 bypass bit span", s, 8 * 3 * 5);
        wr(1, 8'h12);
        rd(1, v); check("R2 div hi readback", v, 8'h12);
        wr(1, 8'h00);
    endtask

    task automatic t_frac();
        int v, s;
        wr(5, 8'h03); wr(2, 12); wr(0, 1); wr(4, 4);
        span(1'b0, s); check("R5 raw12 sample span", s, 12);
        span(1'b1, s); check("R5 raw12 bit span", s, 48);
        wr(2, 13); wr(0, 2); wr(4, 0);
        span(1'b0, s); check("R5 raw13 sample span", s, 26);
        span(1'b1, s); check("R5 raw13 bit span", s, 13 * 2 * 16);
    endtask

    task automatic t_order();
        int v;
        wr(2, 8'hF4); wr(3, 8'h01);
        rd(2, v); check("R6 pre lo", v, 8'hF4);
        rd(3, v); check("R6 pre hi set", v, 8'h01);
        wr(2, 8'h14);
        rd(3, v); check("R6 pre hi cleared", v, 8'h00);
        rd(2, v); check("R6 pre lo new", v, 8'h14);
    endtask

    task automatic t_clamps();
        int v, s;
        wr(5, 8'h03); wr(0, 1); wr(4, 4);
        wr(2, 3);
        span(1'b0, s); check("R7 raw3 as 8", s, 8);
        wr(2, 0);
        span(1'b0, s); check("R7 raw0 as 8", s, 8);
        wr(2, 12); wr(0, 0);
        span(1'b0, s); check("R9 div0 as 1", s, 12);
        wr(5, 8'h01); wr(0, 1);
        wr(4, 1);  span(1'b1, s); check("R8 ovs1 as 16", s, 128);
        wr(4, 3);  span(1'b1, s); check("R8 ovs3 as 16", s, 128);
        wr(4, 15); span(1'b1, s); check("R8 ovs15", s, 120);
        wr(4, 8'hF4);
        rd(4, v); check("R2 ovs field mask", v, 8'h04);
        span(1'b1, s); check("R8 max rate span", s, 32);
        span(1'b0, s); check("R8 max rate sample span", s, 8);
    endtask

    task automatic t_restart();
        int k = 0;
        int hit = 0;
        wr(5, 8'h01); wr(4, 4); wr(1, 0); wr(0, 7);
        repeat (20) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd4;
        @(posedge clk); #1;
        wr_en = 1'b0;
        while (hit == 0 && k < 100) begin
            @(posedge clk); #1;
            k++;
            if (bit_tick) hit = k;
        end
        check("R10 first bit tick after div write", hit, 4 * 4 + 2);
    endtask

    initial begin
        t_reset();
        t_default();
        t_locked();
        t_bypass();
        t_frac();
        t_order();
        t_clamps();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule